// File: doc/BRIEF.md
# Bit-Synchronous HDLC Frame Transmitter

The block turns frames offered one byte at a time into a serial bit stream. Each byte arrives on a valid/ready input, and a marker on the final byte ends the frame. The line advances one bit per cycle in which the bit-clock enable is high. Between frames the line carries either back-to-back flag octets or a steady run of ones, as chosen by a configuration input. Each frame opens with one flag. Its address, control, payload and check bits are protected by zero insertion, and it ends with a 16-bit CRC-CCITT check sequence and a closing flag. In flag fill, that closing flag also serves as the opening flag of a frame that follows at once.

The final byte of a frame may carry fewer than eight bits, so the payload length need not be a whole number of bytes. If the host has no byte ready at the moment the serializer needs one in the middle of a frame, the transmitter ends the frame with an abort pattern instead of a check sequence. It raises a one-cycle status pulse and then returns to the configured fill.

Top module: `hdlc_tx`

## Requirements
- R1: With `cfg_flag_fill` high and no frame pending, the line repeats the flag octet; in time order its bits are 0,1,1,1,1,1,1,0.
- R2: With `cfg_flag_fill` low and no frame pending, the line is held at 1. The fill choice is sampled at the start of each 8-bit fill unit.
- R3: A frame is preceded by exactly one opening flag. In idle-ones fill that flag follows the ones directly. In flag fill, a frame whose first byte is ready by the end of the previous frame's closing flag starts right after that flag, with no extra flag in between.
- R4: Inside a frame (payload and check sequence, not flags or abort), a 0 is inserted after every five consecutive 1s, so the body never shows six 1s in a row.
- R5: Bits are sent least-significant first. The CRC (polynomial x^16+x^12+x^5+1, bit-reflected value 0x8408, preset 0xFFFF) runs over the payload bits. Its ones-complement is sent low bit first, so a receiver running the same CRC over payload plus check bits ends at 0xF0B8.
- R6: On the final byte (`in_last` high), `in_lastbits` gives the number of valid bits, bits [n-1:0]: 0 means 8 and 1 to 7 mean that many. Other bytes always send 8 bits.
- R7: If a byte is needed in the middle of a frame and `in_valid` is low, the frame ends with 0 followed by seven 1s, no check sequence is sent, and the line returns to fill.
- R8: An underrun raises `underrun_pulse` for exactly one clock cycle, in the cycle right after the enabled cycle in which it was detected.
- R9: `in_ready` is high only in cycles where `bit_en` is high and the serializer takes a byte in that cycle. A byte moves when `in_valid` and `in_ready` are both high.
- R10: While `rst` is high, `tx_bit` is 1. `tx_bit` changes only in the cycle after a cycle with `bit_en` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit-clock enable, one line bit per high cycle |
| cfg_flag_fill | input | 1 | Fill between frames: 1 flags, 0 ones |
| in_data | input | 8 | Byte to send, least-significant bit first |
| in_valid | input | 1 | Byte offered |
| in_last | input | 1 | Byte is the final one of its frame |
| in_lastbits | input | 3 | Valid bits of the final byte, 0 meaning 8 |
| in_ready | output | 1 | Byte taken this cycle |
| tx_bit | output | 1 | Serial line output |
| underrun_pulse | output | 1 | One-cycle underrun/abort status |

## Verification
A bench receiver strips the inserted zeros, finds flags and checks the CRC residue of each frame. Directed frames cover the following:
- all-ones payloads, which force the zero insertion;
- residual final bytes from 1 to 7 bits, which tell the length handling apart from whole-byte framing;
- back-to-back frames in flag fill, which expose whether the closing flag is shared;
- frames in idle fill, which must show exactly one opening flag;
- underruns after one or more bytes, which must give an abort and a pulse and no frame.

Random frames with random lengths, residual counts, fill modes and injected underruns are then compared bit by bit with the payload the bench offered. The bit-clock enable is randomly gapped throughout.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

    localparam int UNIT_W = 8;
    localparam int LB_W   = $clog2(UNIT_W);

    typedef logic [UNIT_W-1:0] unit_t;

    // Line patterns, index 0 goes out first
    localparam unit_t FLAG_PAT  = 8'h7E;
    localparam unit_t ABORT_PAT = 8'hFE;
    localparam unit_t ONES_PAT  = 8'hFF;

    typedef enum logic [2:0] {
        ST_FILL,
        ST_OPEN,
        ST_BODY,
        ST_FCS,
        ST_CLOSE,
        ST_ABORT
    } tx_state_e;

    // Byte held by the serializer
    typedef struct packed {
        unit_t            bits;
        logic [LB_W-1:0]  last_idx;
        logic             last;
    } slot_t;

    function automatic slot_t make_slot(unit_t d, logic last, logic [LB_W-1:0] nb);
        slot_t s;
        s.bits     = d;
        s.last     = last;
        s.last_idx = (last && nb != '0) ? LB_W'(nb - 1'b1) : '1;
        return s;
    endfunction

endpackage

// File: rtl/hdlc_crc_gen.sv
module hdlc_crc_gen #(
    parameter int             W        = 16,
    parameter logic [W-1:0]   POLY_REV = 16'h8408,
    parameter logic [W-1:0]   INIT     = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         step,
    input  logic         din,
    output logic [W-1:0] crc_nxt
);
    logic [W-1:0] crc_q;

    always_comb begin
        crc_nxt = crc_q >> 1;
        if (crc_q[0] ^ din) begin
            crc_nxt = crc_nxt ^ POLY_REV;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            crc_q <= INIT;
        end else if (step) begin
            crc_q <= crc_nxt;
        end
    end
endmodule

// File: rtl/hdlc_stuff_ctr.sv
module hdlc_stuff_ctr #(
    parameter int RUN = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic step,
    input  logic din,
    output logic stuff_due
);
    localparam int RW = $clog2(RUN + 1);
    logic [RW-1:0] run_q;

    assign stuff_due = (run_q == RW'(RUN));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            run_q <= '0;
        end else if (step) begin
            run_q <= din ? run_q + 1'b1 : '0;
        end
    end
endmodule

// File: rtl/hdlc_tx.sv
module hdlc_tx
    import hdlc_tx_pkg::*;
#(
    parameter int               CRC_W        = 16,
    parameter logic [CRC_W-1:0] CRC_POLY_REV = 16'h8408,
    parameter int               STUFF_RUN    = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic              cfg_flag_fill,
    input  logic [UNIT_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_last,
    input  logic [LB_W-1:0]   in_lastbits,
    output logic              in_ready,
    output logic              tx_bit,
    output logic              underrun_pulse
);
    localparam int CNT_W = $clog2((CRC_W > UNIT_W) ? CRC_W : UNIT_W);
    localparam logic [CNT_W-1:0] UNIT_LAST = CNT_W'(UNIT_W - 1);
    localparam logic [CNT_W-1:0] FCS_LAST  = CNT_W'(CRC_W - 1);

    tx_state_e         st;
    logic [CNT_W-1:0]  cnt;
    slot_t             cur;
    logic [CRC_W-1:0]  fcs_sh;
    logic              flag_q;
    logic              tx_q;
    logic              pulse_q;

    logic              stuff_due, stuff_now, body_st, unit_end, eff_flag;
    logic              need_byte, take, out_bit, body_emit_w;
    logic [CRC_W-1:0]  crc_nxt;
    logic [LB_W-1:0]   idx;
    slot_t             nxt_slot;

    assign idx       = cnt[LB_W-1:0];
    assign body_st   = (st == ST_BODY) || (st == ST_FCS);
    assign stuff_now = stuff_due && (body_st || (st == ST_CLOSE && cnt == '0));
    assign unit_end  = (cnt == UNIT_LAST);
    assign eff_flag  = (cnt == '0) ? cfg_flag_fill : flag_q;
    assign nxt_slot  = make_slot(in_data, in_last, in_lastbits);
    assign body_emit_w = bit_en && body_st;

    always_comb begin
        need_byte = 1'b0;
        unique case (st)
            ST_FILL:  need_byte = unit_end && eff_flag;
            ST_OPEN:  need_byte = unit_end;
            ST_BODY:  need_byte = !stuff_now && (cnt == CNT_W'(cur.last_idx)) && !cur.last;
            ST_CLOSE: need_byte = !stuff_now && unit_end && cfg_flag_fill;
            default:  need_byte = 1'b0;
        endcase
    end

    assign in_ready = bit_en && need_byte;
    assign take     = in_ready && in_valid;

    always_comb begin
        unique case (st)
            ST_FILL:  out_bit = eff_flag ? FLAG_PAT[idx] : ONES_PAT[idx];
            ST_OPEN:  out_bit = FLAG_PAT[idx];
            ST_CLOSE: out_bit = FLAG_PAT[idx];
            ST_ABORT: out_bit = ABORT_PAT[idx];
            ST_BODY:  out_bit = cur.bits[0];
            ST_FCS:   out_bit = fcs_sh[0];
            default:  out_bit = 1'b1;
        endcase
        if (stuff_now) begin
            out_bit = 1'b0;
        end
    end

    hdlc_crc_gen #(.W(CRC_W), .POLY_REV(CRC_POLY_REV), .INIT('1)) crc_i (
        .clk    (clk),
        .rst    (rst),
        .clear  (take && st != ST_BODY),
        .step   (bit_en && st == ST_BODY && !stuff_now),
        .din    (cur.bits[0]),
        .crc_nxt(crc_nxt)
    );

    hdlc_stuff_ctr #(.RUN(STUFF_RUN)) stuff_i (
        .clk      (clk),
        .rst      (rst),
        .clear    (bit_en && (stuff_now || !body_st)),
        .step     (bit_en && body_st && !stuff_now),
        .din      (out_bit),
        .stuff_due(stuff_due)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_FILL;
            cnt     <= '0;
            cur     <= '0;
            fcs_sh  <= '0;
            flag_q  <= 1'b1;
            tx_q    <= 1'b1;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= 1'b0;
            if (bit_en) begin
                tx_q <= out_bit;
                if (!stuff_now) begin
                    unique case (st)
                        ST_FILL: begin
                            if (cnt == '0) flag_q <= cfg_flag_fill;
                            if (unit_end) begin
                                cnt <= '0;
                                if (take) begin
                                    cur <= nxt_slot;
                                    st  <= ST_BODY;
                                end else if (!eff_flag && in_valid) begin
                                    st <= ST_OPEN;
                                end
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                        ST_OPEN: begin
                            if (unit_end) begin
                                cnt <= '0;
                                if (take) begin
                                    cur <= nxt_slot;
                                    st  <= ST_BODY;
                                end else begin
                                    st      <= ST_ABORT;
                                    pulse_q <= 1'b1;
                                end
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                        ST_BODY: begin
                            cur.bits <= cur.bits >> 1;
                            if (cnt == CNT_W'(cur.last_idx)) begin
                                cnt <= '0;
                                if (cur.last) begin
                                    fcs_sh <= ~crc_nxt;
                                    st     <= ST_FCS;
                                end else if (take) begin
                                    cur <= nxt_slot;
                                end else begin
                                    st      <= ST_ABORT;
                                    pulse_q <= 1'b1;
                                end
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                        ST_FCS: begin
                            fcs_sh <= fcs_sh >> 1;
                            if (cnt == FCS_LAST) begin
                                cnt <= '0;
                                st  <= ST_CLOSE;
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                        ST_CLOSE: begin
                            if (unit_end) begin
                                cnt <= '0;
                                if (take) begin
                                    cur <= nxt_slot;
                                    st  <= ST_BODY;
                                end else begin
                                    st <= ST_FILL;
                                end
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                        default: begin
                            if (unit_end) begin
                                cnt <= '0;
                                st  <= ST_FILL;
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                    endcase
                end
            end
        end
    end

    assign tx_bit         = tx_q;
    assign underrun_pulse = pulse_q;
endmodule

// File: rtl/hdlc_tx_checker.sv
module hdlc_tx_checker #(
    parameter int RUN = 5
) (
    input logic clk,
    input logic rst,
    input logic bit_en,
    input logic in_ready,
    input logic tx_bit,
    input logic underrun_pulse,
    input logic body_emit
);
    logic       body_q, en_q;
    logic [2:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            body_q <= 1'b0;
            en_q   <= 1'b0;
            run_q  <= '0;
        end else begin
            body_q <= body_emit;
            en_q   <= bit_en;
            if (en_q) begin
                if (body_q && tx_bit) begin
                    run_q <= (run_q == 3'd7) ? run_q : run_q + 1'b1;
                end else begin
                    run_q <= '0;
                end
            end
        end
    end

    assert_ones_run_R4: assert property (@(posedge clk) disable iff (rst)
        run_q <= 3'(RUN));

    assert_pulse_single_R8: assert property (@(posedge clk) disable iff (rst)
        underrun_pulse |=> !underrun_pulse);

    assert_pulse_after_enable_R8: assert property (@(posedge clk) disable iff (rst)
        underrun_pulse |-> $past(bit_en));

    assert_ready_on_enable_R9: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> bit_en);

    assert_line_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> $stable(tx_bit));
endmodule

bind hdlc_tx hdlc_tx_checker #(.RUN(STUFF_RUN)) chk_i (
    .clk           (clk),
    .rst           (rst),
    .bit_en        (bit_en),
    .in_ready      (in_ready),
    .tx_bit        (tx_bit),
    .underrun_pulse(underrun_pulse),
    .body_emit     (body_emit_w)
);

// File: tb/hdlc_tx_tb_top.sv
module hdlc_tx_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_en = 1'b0;
    logic       cfg_flag_fill = 1'b1;
    logic [7:0] in_data = '0;
    logic       in_valid = 1'b0;
    logic       in_last = 1'b0;
    logic [2:0] in_lastbits = '0;
    logic       in_ready, tx_bit, underrun_pulse;

    int checks = 0, errors = 0;
    int ones = 0, gap = 0, stuffed = 0, rx_frames = 0, rx_aborts = 0, tot_bits = 0;
    int exp_aborts = 0, n_pulse = 0, viol_r9 = 0, viol_r10 = 0;
    logic [31:0] hist = '0;
    bit rxq[$];
    bit exp_bits[$];
    int exp_len[$];
    int exp_gap[$];
    logic en_q = 1'b0;
    logic tx_prev = 1'b1;
    bit done = 1'b0;

    hdlc_tx dut_i (
        .clk(clk), .rst(rst), .bit_en(bit_en), .cfg_flag_fill(cfg_flag_fill),
        .in_data(in_data), .in_valid(in_valid), .in_last(in_last),
        .in_lastbits(in_lastbits), .in_ready(in_ready), .tx_bit(tx_bit),
        .underrun_pulse(underrun_pulse)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    function automatic logic [15:0] ref_crc(input bit q[$]);
        logic [15:0] c = 16'hFFFF;
        for (int i = 0; i < q.size(); i++) begin
            logic fb = c[0] ^ q[i];
            c = c >> 1;
            if (fb) c = c ^ 16'h8408;
        end
        return c;
    endfunction

    task automatic process_frame();
        int L = rxq.size();
        logic [15:0] c = ref_crc(rxq);
        int n, g, mism;
        rx_frames++;
        check(L >= 16 && c == 16'hF0B8, "R5", "check sequence residue", int'(c), 16'hF0B8);
        if (exp_len.size() == 0) begin
            check(1'b0, "R6", "unexpected frame length", L, -1);
        end else begin
            n = exp_len.pop_front();
            g = exp_gap.pop_front();
            mism = 0;
            check(L - 16 == n, "R6", "payload bit count", L - 16, n);
            for (int i = 0; i < n; i++) begin
                bit e = exp_bits.pop_front();
                if (i < L - 16 && rxq[i] != e) mism++;
            end
            check(mism == 0, "R4", "payload bit mismatches", mism, 0);
            if (g >= 0) check(gap == g, "R3", "flags before frame", gap, g);
        end
        gap = 0;
    endtask

    task automatic rx_bit(input bit b);
        hist = {b, hist[31:1]};
        if (b) begin
            rxq.push_back(1'b1);
            ones++;
            if (ones == 7) begin
                if (rxq.size() > 8) rx_aborts++;
                gap = 0;
            end
            if (ones >= 7) rxq.delete();
        end else if (ones == 5) begin
            stuffed++;
            ones = 0;
        end else if (ones == 6) begin
            for (int k = 0; k < 7 && rxq.size() > 0; k++) void'(rxq.pop_back());
            if (rxq.size() == 0) gap++;
            else process_frame();
            rxq.delete();
            ones = 0;
        end else begin
            rxq.push_back(1'b0);
            ones = 0;
        end
        tot_bits++;
    endtask

    // line capture, one bit per enabled cycle
    always @(posedge clk) begin
        if (!rst && bit_en) begin
            #1;
            rx_bit(tx_bit);
        end
    end

    always @(posedge clk) begin
        if (!rst && underrun_pulse) n_pulse++;
        if (!rst && in_ready && !bit_en) viol_r9++;
        en_q <= bit_en;
    end

    always @(negedge clk) begin
        if (!rst && tx_bit != tx_prev && !en_q) viol_r10++;
        tx_prev = tx_bit;
        bit_en <= (($urandom % 10) < 7);
    end

    task automatic wait_bits(input int n);
        int base = tot_bits;
        wait (tot_bits >= base + n);
        @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] d, input bit last, input logic [2:0] lb);
        in_data = d; in_last = last; in_lastbits = lb; in_valid = 1'b1;
        forever begin
            @(posedge clk);
            if (in_ready) break;
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last = 1'b0;
    endtask

    // pat: 0 random bytes, 1 all ones
    task automatic send_frame(input int nbytes, input logic [2:0] lb,
                              input int gap_exp, input int pat);
        int total = 0;
        logic [7:0] bytes[8];
        for (int i = 0; i < nbytes; i++) begin
            bit last = (i == nbytes - 1);
            int nb = last ? ((lb == 0) ? 8 : int'(lb)) : 8;
            bytes[i] = (pat == 1) ? 8'hFF : 8'($urandom);
            for (int k = 0; k < nb; k++) exp_bits.push_back(bytes[i][k]);
            total += nb;
        end
        exp_len.push_back(total);
        exp_gap.push_back(gap_exp);
        for (int i = 0; i < nbytes; i++) send_byte(bytes[i], i == nbytes - 1, lb);
    endtask

    task automatic send_underrun(input int k);
        for (int i = 0; i < k; i++) send_byte(8'($urandom), 1'b0, 3'd0);
        exp_aborts++;
        wait_bits(40);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R10", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int s0;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(tx_bit == 1'b1, "R10", "line level during reset", int'(tx_bit), 1);
        rst = 1'b0;

        wait (tot_bits >= 32);
        check(hist == 32'h7E7E7E7E, "R1", "flag fill pattern", int'(hist), 32'h7E7E7E7E);
        @(negedge clk);

        send_frame(3, 3'd0, -1, 0);
        send_frame(2, 3'd3, -1, 0);
        wait_bits(40);
        s0 = stuffed;
        send_frame(4, 3'd0, -1, 1);
        wait_bits(40);
        check(stuffed - s0 >= 6, "R4", "inserted zeros in all-ones frame", stuffed - s0, 6);
        send_frame(2, 3'd0, -1, 0);
        send_frame(2, 3'd5, 0, 0);
        wait_bits(40);

        send_underrun(2);
        check(rx_aborts == exp_aborts, "R7", "aborts after underrun", rx_aborts, exp_aborts);
        check(n_pulse == exp_aborts, "R8", "underrun pulses", n_pulse, exp_aborts);
        check(exp_len.size() == 0, "R7", "frames still owed", exp_len.size(), 0);

        cfg_flag_fill = 1'b0;
        wait_bits(24);
        wait_bits(32);
        check(hist == 32'hFFFFFFFF, "R2", "idle ones fill", int'(hist), -1);
        send_frame(3, 3'd0, 1, 0);
        send_frame(1, 3'd1, 1, 0);
        wait_bits(40);
        send_frame(2, 3'd7, 1, 1);
        wait_bits(40);
        send_underrun(1);
        check(rx_aborts == exp_aborts, "R7", "abort in idle fill", rx_aborts, exp_aborts);

        for (int it = 0; it < 16; it++) begin
            bit mode = 1'($urandom % 2);
            cfg_flag_fill = mode;
            wait_bits(24);
            if ($urandom % 6 == 0) begin
                send_underrun(1 + int'($urandom % 3));
            end else begin
                send_frame(1 + int'($urandom % 5), 3'($urandom % 8),
                           mode ? -1 : 1, ($urandom % 4 == 0) ? 1 : 0);
                wait_bits(40);
            end
        end

        wait_bits(40);
        check(exp_len.size() == 0, "R6", "frames not received", exp_len.size(), 0);
        check(rx_aborts == exp_aborts, "R7", "total aborts", rx_aborts, exp_aborts);
        check(n_pulse == exp_aborts, "R8", "total underrun pulses", n_pulse, exp_aborts);
        check(viol_r9 == 0, "R9", "ready without enable", viol_r9, 0);
        check(viol_r10 == 0, "R10", "line change without enable", viol_r10, 0);
        finish_run();
    end
endmodule